// File: doc/BRIEF.md
# Processor Control Register File

This block holds the internal control registers of a processor core. Each register has its own index. There is one combinational read port and one write port that is clocked. Every index carries its own write rule:
- a full-width store;
- a store through a fixed bit mask;
- a write that zeroes the register whatever the data;
- read-only;
- write-only;
- a control strobe that stores nothing and pulses an output line.

One index holds a cycle-count value. A read of that index joins the stored upper half with the live count of a free-running counter.

The core drives a read request and a write request on each cycle. While the core is executing speculatively down a wrong path, it raises a speculation flag and every write is dropped. A read of an index that cannot be read, or a write to an index that cannot be written, produces a one-cycle error pulse. The register set stays as it was when this happens.

Top module: `ctlreg_file`

## Requirements
- R1: After reset every register reads zero, with three exceptions. Index 9 (status/control) reads 0x6. Index 8 (trap base) reads parameter BOOT_BASE. The last scratch index, 7, reads parameter CORE_ID.
- R2: The scratch indices 0..7 and indices 8, 9 and 17 store all 64 written bits. These values read back unchanged on the cycle after the write edge.
- R3: A write to index 10 (exception return address) stores the data with bit 1 forced to zero.
- R4: Indices 11 and 12 (trap request and trap enable) keep only bits 3:0. Indices 13 and 14 (fetch and data privilege mode) keep only bits 4:3, mask 0x18.
- R5: Each of the following indices keeps only the bits of its mask:
  - index 18: 0xffffff0300;
  - indices 19 and 20: bits 63:30;
  - index 21: 0x1ffb;
  - indices 22 and 23: 0x3f;
  - index 24: 0x7f0;
  - index 25: bits 63:57.
- R6: Any write to index 15 (exception summary) or index 16 (exception mask) sets it to zero, whatever the data.
- R7: A read of index 17 returns the stored bits 63:32 joined with the low 32 bits of a cycle counter. The counter is 0 while reset is held and counts up by one on each clock edge after reset.
- R8: With rd_en high, a read of an index that cannot be read raises err_o for exactly the next cycle, and rd_data is zero. The indices that cannot be read are:
  - index 27 (write-only);
  - indices 28 and 29 (strobes);
  - undefined indices 30 and 31.
- R9: A write to index 26 (read-only interrupt level), or to an undefined index, raises err_o on the next cycle and changes no register.
- R10: A write to index 28 pulses flush_o[0] for the next cycle only. A write to index 29 pulses flush_o[1] for the next cycle only. No value is stored.
- R11: While spec_i is high a write has no effect at all: no stored change, no strobe and no error.
- R12: rd_data follows rd_idx in the same cycle. A read in the same cycle as a write to the same index returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read request, enables read error reporting |
| rd_idx | input | IDX_W | Read index |
| rd_data | output | 64 | Read value |
| wr_en | input | 1 | Write request |
| wr_idx | input | IDX_W | Write index |
| wr_data | input | 64 | Write value |
| spec_i | input | 1 | Core is on a wrong speculative path; writes dropped |
| err_o | output | 1 | One-cycle illegal access pulse |
| flush_o | output | 2 | One-cycle control strobe pulses |

## Verification
The bench builds the block with its default parameters:
- IDX_W of 5 with eight scratch slots, which yields 30 defined indices. This leaves two undefined codes at the top, so the illegal-index path can be reached.
- A 32-bit counter half, so the cycle-count join splits at bit 32.
- Distinct non-zero BOOT_BASE and CORE_ID values, so the three special reset values can be told apart from zero and from each other.

A random phase mixes reads, writes and speculation across all 32 codes against the behavioural model.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

    localparam int unsigned DATA_W  = 64;
    localparam int unsigned NUM_STB = 2;
    localparam int unsigned STB_W   = 1;

    // index offsets above the scratch bank
    localparam int unsigned OFS_BASE     = 0;
    localparam int unsigned OFS_CSR      = 1;
    localparam int unsigned OFS_EXC_ADDR = 2;
    localparam int unsigned OFS_TRAP_REQ = 3;
    localparam int unsigned OFS_TRAP_EN  = 4;
    localparam int unsigned OFS_MODE_I   = 5;
    localparam int unsigned OFS_MODE_D   = 6;
    localparam int unsigned OFS_EXC_SUM  = 7;
    localparam int unsigned OFS_EXC_MSK  = 8;
    localparam int unsigned OFS_CYCLE    = 9;
    localparam int unsigned OFS_ICTL     = 10;
    localparam int unsigned OFS_PTB_I    = 11;
    localparam int unsigned OFS_PTB_D    = 12;
    localparam int unsigned OFS_CTEST    = 13;
    localparam int unsigned OFS_CMODE_D  = 14;
    localparam int unsigned OFS_CMODE_M  = 15;
    localparam int unsigned OFS_ASN_I    = 16;
    localparam int unsigned OFS_ASN_D    = 17;
    localparam int unsigned OFS_INT_LVL  = 18;
    localparam int unsigned OFS_HW_CLR   = 19;
    localparam int unsigned OFS_IFLUSH   = 20;
    localparam int unsigned OFS_DFLUSH   = 21;
    localparam int unsigned NUM_FIXED    = 22;

    typedef enum logic [2:0] {
        K_STORE,
        K_CLEAR,
        K_RO,
        K_WO,
        K_STROBE,
        K_CYCLE,
        K_NONE
    } kind_e;

    typedef struct packed {
        kind_e              kind;
        logic [DATA_W-1:0]  mask;
        logic [DATA_W-1:0]  rstv;
        logic [STB_W-1:0]   sel;
    } attr_t;

    function automatic attr_t lookup(input int unsigned idx,
                                     input int unsigned ns,
                                     input logic [DATA_W-1:0] base,
                                     input logic [DATA_W-1:0] cid);
        attr_t a;
        a.kind = K_NONE;
        a.mask = '0;
        a.rstv = '0;
        a.sel  = '0;
        if (idx < ns) begin
            a.kind = K_STORE;
            a.mask = '1;
            if (idx == ns - 1) a.rstv = cid;
        end else begin
            case (idx - ns)
                OFS_BASE:     begin a.kind = K_STORE; a.mask = '1; a.rstv = base; end
                OFS_CSR:      begin a.kind = K_STORE; a.mask = '1; a.rstv = 64'h6; end
                OFS_EXC_ADDR: begin a.kind = K_STORE; a.mask = ~64'h2; end
                OFS_TRAP_REQ,
                OFS_TRAP_EN:  begin a.kind = K_STORE; a.mask = 64'hf; end
                OFS_MODE_I,
                OFS_MODE_D:   begin a.kind = K_STORE; a.mask = 64'h18; end
                OFS_EXC_SUM,
                OFS_EXC_MSK:  a.kind = K_CLEAR;
                OFS_CYCLE:    begin a.kind = K_CYCLE; a.mask = '1; end
                OFS_ICTL:     begin a.kind = K_STORE; a.mask = 64'h0000_00ff_ffff_0300; end
                OFS_PTB_I,
                OFS_PTB_D:    begin a.kind = K_STORE; a.mask = 64'hffff_ffff_c000_0000; end
                OFS_CTEST:    begin a.kind = K_STORE; a.mask = 64'h1ffb; end
                OFS_CMODE_D,
                OFS_CMODE_M:  begin a.kind = K_STORE; a.mask = 64'h3f; end
                OFS_ASN_I:    begin a.kind = K_STORE; a.mask = 64'h7f0; end
                OFS_ASN_D:    begin a.kind = K_STORE; a.mask = 64'hfe00_0000_0000_0000; end
                OFS_INT_LVL:  a.kind = K_RO;
                OFS_HW_CLR:   begin a.kind = K_WO; a.mask = '1; end
                OFS_IFLUSH:   begin a.kind = K_STROBE; a.sel = 1'b0; end
                OFS_DFLUSH:   begin a.kind = K_STROBE; a.sel = 1'b1; end
                default:      a.kind = K_NONE;
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/ctlreg_decode.sv
module ctlreg_decode
    import ctlreg_pkg::*;
#(
    parameter int unsigned       IDX_W       = 5,
    parameter int unsigned       NUM_SCRATCH = 8,
    parameter logic [DATA_W-1:0] BOOT_BASE   = 64'h0,
    parameter logic [DATA_W-1:0] CORE_ID     = 64'h0
) (
    input  logic [IDX_W-1:0] idx,
    output attr_t            attr
);
    always_comb begin
        attr = lookup(32'(idx), NUM_SCRATCH, BOOT_BASE, CORE_ID);
    end
endmodule

// File: rtl/ctlreg_cycle.sv
module ctlreg_cycle #(
    parameter int unsigned CYC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CYC_W-1:0] count
);
    typedef struct packed {
        logic [CYC_W-1:0] cnt;
    } cyc_state_t;

    cyc_state_t cs_d, cs_q;

    always_comb begin
        cs_d     = cs_q;
        cs_d.cnt = cs_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign count = cs_q.cnt;

    // R7
    cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> count == CYC_W'($past(count) + 1'b1));
endmodule

// File: rtl/ctlreg_store.sv
module ctlreg_store
    import ctlreg_pkg::*;
#(
    parameter int unsigned       IDX_W       = 5,
    parameter int unsigned       NUM_SCRATCH = 8,
    parameter logic [DATA_W-1:0] BOOT_BASE   = 64'h0,
    parameter logic [DATA_W-1:0] CORE_ID     = 64'h0,
    localparam int unsigned      NREG        = NUM_SCRATCH + NUM_FIXED
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        spec_i,
    input  attr_t                       wr_attr,
    input  logic                        rd_err,
    output logic [NREG-1:0][DATA_W-1:0] regs_o,
    output logic                        err_o,
    output logic [NUM_STB-1:0]          stb_o
);
    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] regs;
        logic                        err;
        logic [NUM_STB-1:0]          stb;
    } st_t;

    function automatic st_t reset_image();
        st_t s;
        attr_t a;
        s = '0;
        for (int i = 0; i < NREG; i++) begin
            a = lookup(i, NUM_SCRATCH, BOOT_BASE, CORE_ID);
            s.regs[i] = a.rstv;
        end
        return s;
    endfunction

    localparam st_t RST_S = reset_image();

    st_t st_d, st_q;
    logic wr_live;

    assign wr_live = wr_en && !spec_i;

    always_comb begin
        st_d     = st_q;
        st_d.err = rd_err;
        st_d.stb = '0;
        if (wr_live) begin
            unique case (wr_attr.kind)
                K_STORE, K_CYCLE, K_WO: st_d.regs[wr_idx] = wr_data & wr_attr.mask;
                K_CLEAR:                st_d.regs[wr_idx] = '0;
                K_STROBE:               st_d.stb[wr_attr.sel] = 1'b1;
                default:                st_d.err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST_S;
        else        st_q <= st_d;
    end

    assign regs_o = st_q.regs;
    assign err_o  = st_q.err;
    assign stb_o  = st_q.stb;

    // R6
    clr_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_live && wr_attr.kind == K_CLEAR) |=> regs_o[$past(wr_idx)] == '0);

    // R9
    bad_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_live && (wr_attr.kind == K_RO || wr_attr.kind == K_NONE)) |=> err_o && $stable(regs_o));

    // R11
    spec_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && spec_i && !rd_err) |=> !err_o && stb_o == '0 && $stable(regs_o));

    // R10
    stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb_o));
endmodule

// File: rtl/ctlreg_file.sv
module ctlreg_file
    import ctlreg_pkg::*;
#(
    parameter int unsigned       IDX_W       = 5,
    parameter int unsigned       NUM_SCRATCH = 8,
    parameter int unsigned       CYC_W       = 32,
    parameter logic [DATA_W-1:0] BOOT_BASE   = 64'h0000_0000_4000_8000,
    parameter logic [DATA_W-1:0] CORE_ID     = 64'h0000_0000_0000_0003
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [63:0]      rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [63:0]      wr_data,
    input  logic             spec_i,
    output logic             err_o,
    output logic [1:0]       flush_o
);
    localparam int unsigned NREG = NUM_SCRATCH + NUM_FIXED;

    attr_t                       rd_attr, wr_attr;
    logic [NREG-1:0][DATA_W-1:0] regs;
    logic [CYC_W-1:0]            cyc;
    logic                        rd_bad, rd_err;

    ctlreg_decode #(.IDX_W(IDX_W), .NUM_SCRATCH(NUM_SCRATCH),
                    .BOOT_BASE(BOOT_BASE), .CORE_ID(CORE_ID))
        u_rd_dec (.idx(rd_idx), .attr(rd_attr));

    ctlreg_decode #(.IDX_W(IDX_W), .NUM_SCRATCH(NUM_SCRATCH),
                    .BOOT_BASE(BOOT_BASE), .CORE_ID(CORE_ID))
        u_wr_dec (.idx(wr_idx), .attr(wr_attr));

    ctlreg_cycle #(.CYC_W(CYC_W)) u_cyc (.clk(clk), .rst_n(rst_n), .count(cyc));

    ctlreg_store #(.IDX_W(IDX_W), .NUM_SCRATCH(NUM_SCRATCH),
                   .BOOT_BASE(BOOT_BASE), .CORE_ID(CORE_ID))
        u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_idx  (wr_idx),
            .wr_data (wr_data),
            .spec_i  (spec_i),
            .wr_attr (wr_attr),
            .rd_err  (rd_err),
            .regs_o  (regs),
            .err_o   (err_o),
            .stb_o   (flush_o)
        );

    always_comb begin
        rd_bad  = 1'b0;
        rd_data = '0;
        unique case (rd_attr.kind)
            K_STORE, K_RO, K_CLEAR: rd_data = regs[rd_idx];
            K_CYCLE:                rd_data = {regs[rd_idx][DATA_W-1:CYC_W], cyc};
            default:                rd_bad  = 1'b1;
        endcase
    end

    assign rd_err = rd_en && rd_bad;

    // R8
    rd_err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |=> err_o);

    // R8
    rd_bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_bad |-> rd_data == '0);
endmodule

// File: tb/tb_ctlreg_file.sv
module tb_ctlreg_file;
    localparam logic [63:0] BASE_V = 64'h0000_0000_4000_8000;
    localparam logic [63:0] CID_V  = 64'h0000_0000_0000_0003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_idx = '0;
    logic [63:0] rd_data;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic        spec_i = 1'b0;
    logic        err_o;
    logic [1:0]  flush_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    ctlreg_file dut (.clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(rd_idx),
        .rd_data(rd_data), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .spec_i(spec_i), .err_o(err_o), .flush_o(flush_o));

    // reference model state
    logic [63:0] m_regs [32];
    logic [31:0] m_cyc;

    // class codes: 0 masked store, 1 clear, 2 read-only, 3 write-only,
    // 4 strobe 0, 5 strobe 1, 6 cycle, 7 undefined
    function automatic int cls(int i);
        if (i < 8) return 0;
        case (i)
            15, 16: return 1;
            26:     return 2;
            27:     return 3;
            28:     return 4;
            29:     return 5;
            17:     return 6;
            30, 31: return 7;
            default: return 0;
        endcase
    endfunction

    function automatic logic [63:0] msk(int i);
        case (i)
            10:     return ~64'h2;
            11, 12: return 64'hf;
            13, 14: return 64'h18;
            18:     return 64'h0000_00ff_ffff_0300;
            19, 20: return 64'hffff_ffff_c000_0000;
            21:     return 64'h1ffb;
            22, 23: return 64'h3f;
            24:     return 64'h7f0;
            25:     return 64'hfe00_0000_0000_0000;
            default: return '1;
        endcase
    endfunction

    function automatic logic [63:0] m_read(int i);
        int c = cls(i);
        if (c == 0 || c == 1 || c == 2) return m_regs[i];
        if (c == 6) return {m_regs[i][63:32], m_cyc};
        return '0;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic m_reset();
        for (int i = 0; i < 32; i++) m_regs[i] = '0;
        m_regs[7] = CID_V;
        m_regs[8] = BASE_V;
        m_regs[9] = 64'h6;
        m_cyc = '0;
    endtask

    task automatic step(bit re, int ri, bit we, int wi, logic [63:0] wd, bit sp, string req);
        logic [63:0] e_rd;
        bit          e_err;
        logic [1:0]  e_fl;
        int          c;
        rd_en = re; rd_idx = ri[4:0];
        wr_en = we; wr_idx = wi[4:0]; wr_data = wd; spec_i = sp;
        #1;
        e_rd = m_read(ri);
        chk(rd_data === e_rd, req, "rd_data", rd_data, e_rd);
        c = cls(ri);
        e_err = re && (c == 3 || c == 4 || c == 5 || c == 7);
        e_fl  = 2'b00;
        @(posedge clk);
        if (we && !sp) begin
            c = cls(wi);
            case (c)
                0, 3, 6: m_regs[wi] = wd & msk(wi);
                1:       m_regs[wi] = '0;
                4:       e_fl[0] = 1'b1;
                5:       e_fl[1] = 1'b1;
                default: e_err = 1'b1;
            endcase
        end
        m_cyc = m_cyc + 1;
        @(negedge clk);
        chk(err_o === e_err, req, "err_o", {63'b0, err_o}, {63'b0, e_err});
        chk(flush_o === e_fl, req, "flush_o", {62'b0, flush_o}, {62'b0, e_fl});
    endtask

    task automatic wr(int i, logic [63:0] d, string req);
        step(0, 0, 1, i, d, 0, req);
    endtask

    task automatic rd(int i, string req);
        step(1, i, 0, 0, '0, 0, req);
    endtask

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values, R8 unreadable indices
        for (int i = 0; i < 32; i++) rd(i, (i >= 27) ? "R8" : "R1");

        // R2 full-width stores
        for (int i = 0; i < 10; i++) wr(i, 64'hdead_beef_0000_0000 | 64'(i * 17), "R2");
        for (int i = 0; i < 10; i++) rd(i, "R2");

        // R3 exception address bit 1
        wr(10, '1, "R3"); rd(10, "R3");
        // R4 trap and mode masks
        for (int i = 11; i <= 14; i++) begin wr(i, '1, "R4"); rd(i, "R4"); end
        // R5 remaining masks
        for (int i = 18; i <= 25; i++) begin wr(i, '1, "R5"); rd(i, "R5"); end
        for (int i = 18; i <= 25; i++) begin wr(i, 64'h5a5a_a5a5_3c3c_c3c3, "R5"); rd(i, "R5"); end

        // R6 write clears
        wr(15, '1, "R6"); rd(15, "R6");
        wr(16, 64'h1234, "R6"); rd(16, "R6");

        // R7 cycle merge
        wr(17, 64'habcd_0123_ffff_ffff, "R7");
        for (int k = 0; k < 4; k++) rd(17, "R7");

        // R9 read-only and undefined writes
        wr(26, '1, "R9"); rd(26, "R9");
        wr(30, '1, "R9"); wr(31, 64'h7, "R9"); rd(26, "R9");

        // R10 strobes, nothing stored
        wr(28, '1, "R10"); wr(29, '1, "R10"); rd(0, "R10");
        wr(27, 64'hfeed, "R10");

        // R11 speculation drops writes
        step(1, 3, 1, 3, 64'h1111, 1, "R11"); rd(3, "R11");
        step(0, 0, 1, 28, '1, 1, "R11");
        step(0, 0, 1, 26, '1, 1, "R11");
        step(0, 0, 1, 15, '0, 1, "R11");

        // R12 same-cycle read returns old value
        step(1, 4, 1, 4, 64'h9999_8888, 0, "R12"); rd(4, "R12");

        // R12 random mix
        for (int n = 0; n < 3000; n++)
            step($urandom_range(0, 1), $urandom_range(0, 31),
                 $urandom_range(0, 1), $urandom_range(0, 31),
                 {$urandom, $urandom}, ($urandom_range(0, 7) == 0), "R12");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule